// File: doc/BRIEF.md
# MSI Capability Register File

This block is the message-signalled-interrupt capability structure of one PCI function's configuration space. The configuration decoder has already matched the capability's base offset. It then hands this block a dword index relative to that base, a read or write strobe, four byte enables and write data. The block holds the message control word, the message address, the message data and, optionally, a per-vector mask. It also shows a per-vector pending vector that the interrupt logic supplies. It drives the live enable, the allocated vector count, the address, the data and the mask to the logic that issues the interrupt messages.

Three build-time parameters set the layout and the control word: the vector count (a power of two from 1 to 32), 64-bit addressing and per-vector masking. The write masks follow from the same parameters. A field that the build does not support cannot be written, and it reads as zero or as its fixed value. Reads are registered. Read data appears, with a valid flag, on the cycle after the strobe.

Top module: `msi_cap_regs`

## Requirements
- R1: Dword 0 reads the capability ID 0x05 in bits [7:0] and the NEXT_PTR parameter in bits [15:8]. Writes cannot change either byte.
- R2: The control word sits in bits [31:16] of dword 0. Bit 0 is the enable. Bits [3:1] hold log2(NUM_VEC) as the capable field. Bits [6:4] hold the enabled-vector field. Bit 7 equals ADDR64 and bit 8 equals PVM. Bits [15:9] read zero.
- R3: Only control bits 0 and [6:4] are writable, and only through byte lane 2. Every other control bit ignores writes.
- R4: A write of the enabled-vector field with a value above the capable field stores the capable value. msi_vec_cnt equals 2 to the power of the stored field.
- R5: The lower address is dword 1. Bits [1:0] always read zero and bits [31:2] are writable per byte lane.
- R6: With ADDR64=1 the upper address is a fully writable dword 2 and drives msi_addr[63:32]. With ADDR64=0, msi_addr[63:32] is zero.
- R7: The message data register is dword 3 when ADDR64=1 and dword 2 when ADDR64=0. Bits [15:0] are writable and bits [31:16] read zero.
- R8: With PVM=1 the mask register is the dword after the data register. Only bits NUM_VEC-1..0 are writable and the higher bits read zero. With PVM=0, msi_mask is zero.
- R9: With PVM=1 the dword after the mask register reads msi_pending limited to bits NUM_VEC-1..0. Writes to it have no effect.
- R10: A write changes only the byte lanes whose byte enable is set.
- R11: Reset clears the enable, the enabled-vector field, the address, the data and the mask to zero.
- R12: A read strobe raises cfg_rvalid on the next cycle, with the data as it stood on the strobe cycle. A dword outside the configured layout reads zero, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sel | input | 1 | Access strobe, one cycle per access |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_dw | input | 3 | Dword index from capability base |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rvalid | output | 1 | Read data valid |
| cfg_rdata | output | 32 | Read data |
| msi_pending | input | 32 | Pending bits from interrupt logic |
| msi_en | output | 1 | Message enable |
| msi_mme | output | 3 | Enabled-vector field (log2 of count) |
| msi_vec_cnt | output | 6 | Vectors allocated by software |
| msi_addr | output | 64 | Message address |
| msi_data | output | 16 | Message data |
| msi_mask | output | 32 | Per-vector mask bits |

## Verification
The assertions assume that cfg_sel is a single-cycle strobe, that cfg_dw is known whenever cfg_sel is high, and that accesses are never made back to back. They also assume reset is held for at least one clock edge. The bench meets these by changing inputs only on the falling edge and by dropping cfg_sel on the edge after each access. It runs two builds side by side: a full one (8 vectors, 64-bit, masking) and a minimal one (1 vector, 32-bit, no masking). Both share one request bus, so every access to a dword that one build maps and the other does not also tests the unmapped-dword rule.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

    localparam logic [7:0] MSI_CAP_ID = 8'h05;

    // log2 of a power-of-two vector count
    function automatic int unsigned msi_log2(input int unsigned n);
        int unsigned r;
        r = 0;
        for (int unsigned i = 0; i < 6; i++) begin
            if ((32'd1 << i) == n) r = i;
        end
        return r;
    endfunction

    // Mask covering vector bits n-1..0
    function automatic logic [31:0] msi_vec_mask(input int unsigned n);
        logic [31:0] m;
        m = '0;
        for (int unsigned i = 0; i < 32; i++) begin
            if (i < n) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/msi_masked_reg.sv
module msi_masked_reg #(
    parameter int unsigned       WIDTH = 32,
    parameter logic [WIDTH-1:0]  WMASK = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [WIDTH/8-1:0]   be,
    input  logic [WIDTH-1:0]     wdata,
    output logic [WIDTH-1:0]     q
);
    localparam int unsigned NBYTES = WIDTH / 8;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            for (int unsigned b = 0; b < NBYTES; b++) begin
                if (be[b]) q[b*8 +: 8] <= wdata[b*8 +: 8] & WMASK[b*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/msi_ctrl_reg.sv
module msi_ctrl_reg #(
    parameter logic [2:0] MMC = 3'd0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       en_in,
    input  logic [2:0] mme_in,
    output logic       en_q,
    output logic [2:0] mme_q
);
    logic [2:0] mme_clamped;

    always_comb begin
        mme_clamped = (mme_in > MMC) ? MMC : mme_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            mme_q <= 3'd0;
        end else if (wr_en) begin
            en_q  <= en_in;
            mme_q <= mme_clamped;
        end
    end
endmodule

// File: rtl/msi_rd_mux.sv
module msi_rd_mux #(
    parameter bit         ADDR64   = 1'b1,
    parameter bit         PVM      = 1'b1,
    parameter logic [7:0] NEXT_PTR = 8'h00,
    parameter logic [2:0] DW_DATA  = 3'd3
) (
    input  logic [2:0]  dw,
    input  logic [15:0] ctl,
    input  logic [63:0] addr,
    input  logic [15:0] data,
    input  logic [31:0] mask,
    input  logic [31:0] pend,
    output logic [31:0] word
);
    import msi_cap_pkg::*;
    localparam logic [2:0] DW_MASK = DW_DATA + 3'd1;
    localparam logic [2:0] DW_PEND = DW_DATA + 3'd2;

    always_comb begin
        word = '0;
        if (dw == 3'd0)                        word = {ctl, NEXT_PTR, MSI_CAP_ID};
        else if (dw == 3'd1)                   word = addr[31:0];
        else if (ADDR64 && dw == 3'd2)         word = addr[63:32];
        else if (dw == DW_DATA)                word = {16'h0000, data};
        else if (PVM && dw == DW_MASK)         word = mask;
        else if (PVM && dw == DW_PEND)         word = pend;
    end
endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs #(
    parameter int unsigned NUM_VEC  = 8,
    parameter bit          ADDR64   = 1'b1,
    parameter bit          PVM      = 1'b1,
    parameter logic [7:0]  NEXT_PTR = 8'h00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_sel,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_dw,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic        cfg_rvalid,
    output logic [31:0] cfg_rdata,
    input  logic [31:0] msi_pending,
    output logic        msi_en,
    output logic [2:0]  msi_mme,
    output logic [5:0]  msi_vec_cnt,
    output logic [63:0] msi_addr,
    output logic [15:0] msi_data,
    output logic [31:0] msi_mask
);
    import msi_cap_pkg::*;

    localparam logic [2:0]  MMC      = 3'(msi_log2(NUM_VEC));
    localparam logic [2:0]  DW_DATA  = ADDR64 ? 3'd3 : 3'd2;
    localparam logic [2:0]  DW_MASK  = DW_DATA + 3'd1;
    localparam logic [31:0] VEC_MASK = msi_vec_mask(NUM_VEC);

    logic        wr;
    logic [31:0] addr_lo;
    logic [31:0] addr_hi;
    logic [31:0] mask_q;
    logic [15:0] ctl_word;
    logic [31:0] pend_vis;
    logic [31:0] rd_word;

    assign wr = cfg_sel & cfg_we;

    msi_ctrl_reg #(.MMC(MMC)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr && cfg_dw == 3'd0 && cfg_be[2]),
        .en_in  (cfg_wdata[16]),
        .mme_in (cfg_wdata[22:20]),
        .en_q   (msi_en),
        .mme_q  (msi_mme)
    );

    msi_masked_reg #(.WIDTH(32), .WMASK(32'hFFFF_FFFC)) u_addr_lo (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr && cfg_dw == 3'd1),
        .be    (cfg_be),
        .wdata (cfg_wdata),
        .q     (addr_lo)
    );

    generate
        if (ADDR64) begin : g_addr_hi
            msi_masked_reg #(.WIDTH(32), .WMASK(32'hFFFF_FFFF)) u_addr_hi (
                .clk   (clk),
                .rst_n (rst_n),
                .wr_en (wr && cfg_dw == 3'd2),
                .be    (cfg_be),
                .wdata (cfg_wdata),
                .q     (addr_hi)
            );
        end else begin : g_no_addr_hi
            assign addr_hi = '0;
        end
    endgenerate

    msi_masked_reg #(.WIDTH(16), .WMASK(16'hFFFF)) u_data (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr && cfg_dw == DW_DATA),
        .be    (cfg_be[1:0]),
        .wdata (cfg_wdata[15:0]),
        .q     (msi_data)
    );

    generate
        if (PVM) begin : g_mask
            msi_masked_reg #(.WIDTH(32), .WMASK(VEC_MASK)) u_mask (
                .clk   (clk),
                .rst_n (rst_n),
                .wr_en (wr && cfg_dw == DW_MASK),
                .be    (cfg_be),
                .wdata (cfg_wdata),
                .q     (mask_q)
            );
            assign pend_vis = msi_pending & VEC_MASK;
        end else begin : g_no_mask
            assign mask_q   = '0;
            assign pend_vis = '0;
        end
    endgenerate

    assign ctl_word    = {7'b0, PVM, ADDR64, msi_mme, MMC, msi_en};
    assign msi_addr    = {addr_hi, addr_lo};
    assign msi_mask    = mask_q;
    assign msi_vec_cnt = 6'd1 << msi_mme;

    msi_rd_mux #(
        .ADDR64   (ADDR64),
        .PVM      (PVM),
        .NEXT_PTR (NEXT_PTR),
        .DW_DATA  (DW_DATA)
    ) u_rd_mux (
        .dw   (cfg_dw),
        .ctl  (ctl_word),
        .addr (msi_addr),
        .data (msi_data),
        .mask (mask_q),
        .pend (pend_vis),
        .word (rd_word)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rvalid <= 1'b0;
            cfg_rdata  <= '0;
        end else begin
            cfg_rvalid <= cfg_sel & ~cfg_we;
            if (cfg_sel & ~cfg_we) cfg_rdata <= rd_word;
        end
    end
endmodule

// File: rtl/msi_cap_chk.sv
module msi_cap_chk #(
    parameter int unsigned NUM_VEC  = 8,
    parameter bit          ADDR64   = 1'b1,
    parameter bit          PVM      = 1'b1,
    parameter logic [7:0]  NEXT_PTR = 8'h00
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_sel,
    input logic        cfg_we,
    input logic [2:0]  cfg_dw,
    input logic [3:0]  cfg_be,
    input logic        cfg_rvalid,
    input logic [31:0] cfg_rdata,
    input logic        msi_en,
    input logic [2:0]  msi_mme,
    input logic [5:0]  msi_vec_cnt,
    input logic [63:0] msi_addr,
    input logic [31:0] msi_mask
);
    localparam logic [2:0]  CAP_LOG2 = 3'(msi_cap_pkg::msi_log2(NUM_VEC));
    localparam logic [31:0] VMASK    = msi_cap_pkg::msi_vec_mask(NUM_VEC);

    p_capid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rvalid && $past(cfg_dw) == 3'd0 |-> cfg_rdata[15:0] == {NEXT_PTR, 8'h05});

    p_ctl_ro_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rvalid && $past(cfg_dw) == 3'd0 |->
            cfg_rdata[19:17] == CAP_LOG2 && cfg_rdata[23] == ADDR64 &&
            cfg_rdata[24] == PVM && cfg_rdata[31:25] == 7'd0);

    p_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_sel && cfg_we && cfg_dw == 3'd0 && cfg_be[2]) |=>
            $stable(msi_en) && $stable(msi_mme));

    p_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        msi_mme <= CAP_LOG2 && msi_vec_cnt == (6'd1 << msi_mme));

    p_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        msi_addr[1:0] == 2'b00);

    p_addr_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ADDR64 |-> msi_addr[63:32] == 32'd0);

    p_mask_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_mask & ~VMASK) == 32'd0 && (PVM || msi_mask == 32'd0));

    p_rvalid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sel && !cfg_we |=> cfg_rvalid);
endmodule

bind msi_cap_regs msi_cap_chk #(
    .NUM_VEC  (NUM_VEC),
    .ADDR64   (ADDR64),
    .PVM      (PVM),
    .NEXT_PTR (NEXT_PTR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_sel     (cfg_sel),
    .cfg_we      (cfg_we),
    .cfg_dw      (cfg_dw),
    .cfg_be      (cfg_be),
    .cfg_rvalid  (cfg_rvalid),
    .cfg_rdata   (cfg_rdata),
    .msi_en      (msi_en),
    .msi_mme     (msi_mme),
    .msi_vec_cnt (msi_vec_cnt),
    .msi_addr    (msi_addr),
    .msi_mask    (msi_mask)
);

// File: tb/tb_msi_cap_regs.sv
`timescale 1ns/1ps
module tb_msi_cap_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_sel = 1'b0, cfg_we = 1'b0;
    logic [2:0]  cfg_dw = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] msi_pending = '0;

    logic        rv_a, rv_b, en_a, en_b;
    logic [31:0] rd_a, rd_b, mask_a, mask_b;
    logic [2:0]  mme_a, mme_b;
    logic [5:0]  cnt_a, cnt_b;
    logic [63:0] addr_a, addr_b;
    logic [15:0] data_a, data_b;

    int n_chk = 0, n_fail = 0;
    logic [31:0] ra, rb;

    always #2.5 clk = ~clk;

    // Full build: 8 vectors, 64-bit, masking
    msi_cap_regs dut (
        .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_we(cfg_we),
        .cfg_dw(cfg_dw), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rvalid(rv_a), .cfg_rdata(rd_a), .msi_pending(msi_pending),
        .msi_en(en_a), .msi_mme(mme_a), .msi_vec_cnt(cnt_a),
        .msi_addr(addr_a), .msi_data(data_a), .msi_mask(mask_a));

    // Minimal build: 1 vector, 32-bit, no masking
    msi_cap_regs #(.NUM_VEC(1), .ADDR64(1'b0), .PVM(1'b0), .NEXT_PTR(8'h40)) dut_min (
        .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_we(cfg_we),
        .cfg_dw(cfg_dw), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rvalid(rv_b), .cfg_rdata(rd_b), .msi_pending(msi_pending),
        .msi_en(en_b), .msi_mme(mme_b), .msi_vec_cnt(cnt_b),
        .msi_addr(addr_b), .msi_data(data_b), .msi_mask(mask_b));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] dw, input logic [3:0] be, input logic [31:0] wd);
        @(negedge clk);
        cfg_sel = 1'b1; cfg_we = 1'b1; cfg_dw = dw; cfg_be = be; cfg_wdata = wd;
        @(negedge clk);
        cfg_sel = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] dw);
        @(negedge clk);
        cfg_sel = 1'b1; cfg_we = 1'b0; cfg_dw = dw;
        @(negedge clk);
        cfg_sel = 1'b0;
        chk("R12 rvalid full", {63'd0, rv_a}, 64'd1);
        chk("R12 rvalid min", {63'd0, rv_b}, 64'd1);
        ra = rd_a; rb = rd_b;
    endtask

    // dword 0 expected from R1/R2
    function automatic logic [31:0] dw0(input logic [7:0] nxt, input logic [2:0] cap,
                                        input bit a64, input bit pvm,
                                        input logic [2:0] mme, input bit en);
        return {7'd0, pvm, a64, mme, cap, en, nxt, 8'h05};
    endfunction

    function automatic logic [31:0] lanes(input logic [3:0] be, input logic [31:0] d);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[b*8 +: 8] = be[b] ? d[b*8 +: 8] : 8'h00;
        return r;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        chk("R11 en", {62'd0, en_a, en_b}, 64'd0);
        chk("R11 addr", addr_a | addr_b, 64'd0);
        chk("R11 data/mask", {data_a, data_b, mask_a}, 64'd0);
        chk("R4 reset count", {52'd0, cnt_a, cnt_b}, {52'd0, 6'd1, 6'd1});
        rd(3'd0);
        chk("R1 R2 reset dw0 full", ra, dw0(8'h00, 3'd3, 1, 1, 3'd0, 0));
        chk("R1 R2 reset dw0 min", rb, dw0(8'h40, 3'd0, 0, 0, 3'd0, 0));

        // R3 R4: sweep enabled-vector field with read-only bits attacked
        for (int v = 0; v < 8; v++) begin
            logic en;
            logic [2:0] ea, eb;
            en = v[0];
            ea = (v > 3) ? 3'd3 : 3'(v);
            eb = 3'd0;
            wr(3'd0, 4'hF, {8'h00, 1'b0, 3'(v), 3'b101, en, 16'h7733});
            rd(3'd0);
            chk("R3 R4 dw0 full", ra, dw0(8'h00, 3'd3, 1, 1, ea, en));
            chk("R3 R4 dw0 min", rb, dw0(8'h40, 3'd0, 0, 0, eb, en));
            chk("R4 count full", {58'd0, cnt_a}, 64'd1 << ea);
            chk("R4 count min", {58'd0, cnt_b}, 64'd1);
            chk("R3 en", {62'd0, en_a, en_b}, {62'd0, en, en});
        end

        // R3 R10: dword 0 write without lane 2 changes nothing
        wr(3'd0, 4'b1011, 32'h0000_0000);
        chk("R3 lane2 off en", {62'd0, en_a, en_b}, {62'd0, 1'b1, 1'b1});
        chk("R3 lane2 off mme", {61'd0, mme_a}, 64'd3);

        // R5: lower address alignment and byte lanes
        wr(3'd1, 4'hF, 32'hFFFF_FFFF);
        chk("R5 addr lo full", {32'd0, addr_a[31:0]}, 64'hFFFF_FFFC);
        chk("R5 addr lo min", addr_b, 64'hFFFF_FFFC);
        wr(3'd1, 4'b0101, 32'h0000_0000);
        rd(3'd1);
        chk("R5 R10 addr lo partial", {32'd0, ra}, 64'hFF00_FF00);

        // R6 R7: dword 2 is upper address (full) and data (min)
        wr(3'd2, 4'hF, 32'h1234_5679);
        chk("R6 addr hi full", {32'd0, addr_a[63:32]}, 64'h1234_5679);
        chk("R6 addr hi min", addr_b[63:32], 32'd0);
        chk("R7 data min", {48'd0, data_b}, 64'h5679);
        rd(3'd2);
        chk("R7 data min upper zero", {32'd0, rb}, 64'h5679);

        // R7 R10 R12: byte-enable sweep on full-build data dword 3
        for (int b = 0; b < 16; b++) begin
            wr(3'd3, 4'hF, 32'h0000_0000);
            wr(3'd3, 4'(b), 32'hA5C3_5A3C);
            rd(3'd3);
            chk("R7 R10 data full", {32'd0, ra}, {32'd0, 16'h0, lanes(4'(b), 32'h0000_5A3C)});
            chk("R12 unmapped dw3 min", {32'd0, rb}, 64'd0);
        end

        // R8: mask writable bits
        wr(3'd4, 4'hF, 32'hFFFF_FFFF);
        chk("R8 mask full", {32'd0, mask_a}, 64'hFF);
        chk("R8 mask min", {32'd0, mask_b}, 64'd0);
        wr(3'd4, 4'b0001, 32'h0000_00A5);
        rd(3'd4);
        chk("R8 mask readback", {32'd0, ra}, 64'hA5);
        chk("R12 unmapped dw4 min", {32'd0, rb}, 64'd0);

        // R9: pending read-only, limited to vector bits
        msi_pending = 32'hFFFF_FF5A;
        wr(3'd5, 4'hF, 32'h0000_0000);
        rd(3'd5);
        chk("R9 pending full", {32'd0, ra}, 64'h5A);
        chk("R12 unmapped dw5 min", {32'd0, rb}, 64'd0);
        msi_pending = 32'h0000_0081;
        rd(3'd5);
        chk("R9 pending follows", {32'd0, ra}, 64'h81);

        // R12: unmapped dwords read zero and writes are ignored
        wr(3'd6, 4'hF, 32'hFFFF_FFFF);
        wr(3'd7, 4'hF, 32'hFFFF_FFFF);
        rd(3'd6);
        chk("R12 dw6", {ra, rb}, 64'd0);
        rd(3'd7);
        chk("R12 dw7", {ra, rb}, 64'd0);
        chk("R12 state kept full", {addr_a, mask_a, data_a, 13'd0, mme_a},
            {64'h1234_5679_FF00_FF00, 32'hA5, 16'h5A3C, 13'd0, 3'd3});
        chk("R12 state kept min", {addr_b[31:0], data_b}, {32'hFF00_FF00, 16'h5679});

        // R11: reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R11 clear full", {addr_a, mask_a, data_a, 12'd0, en_a, mme_a}, 128'd0);
        chk("R11 clear min", {addr_b, data_b, en_b, mme_b}, 84'd0);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule